// File: doc/BRIEF.md
# Expansion Slot Interrupt Aggregator

This block gathers the active-low interrupt request lines of seven expansion slots, numbered 9 through F, into one interrupt. Each request line is synchronised and then gated by its own bit in a slot mask register. The surviving requests are shown as an active-high pending set that software can read. Every enabled request feeds a single wired-OR style combined line. When that line falls from idle to active, an umbrella flag is set and drives the block's interrupt output.

Software sets or clears mask bits with one write. The top data bit chooses the direction, and the lower bits choose the slots. Software clears the umbrella flag through the same register port. It then reads the pending set, or the encoded highest pending slot, to decide which slot to serve next. Slots are served from the top slot downward. The flag fires again whenever a request is still pending at the moment it is cleared, so a request that is still being held is never lost.

Top module: `slot_irq_agg`

## Requirements
- R1: After reset, every mask bit is 0, the umbrella flag is 0, the pending set is empty, and the combined line is high (idle).
- R2: A write to register address 0 with data bit 7 = 1 sets each mask bit whose data bit (6..0) is 1 and leaves the other mask bits unchanged. Reading address 0 returns the mask in bits 6..0, with bit 7 reading 0.
- R3: A write to address 0 with data bit 7 = 0 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged. Writing 0x7F this way clears every mask bit.
- R4: Reading address 1 returns the pending set: bit i is 1 exactly when synchronised request line i is low and mask bit i is 1. Bit 7 reads 0.
- R5: Each request line passes through two flip-flops before it is used. A level driven before clock edge A shows in the pending set only after edge A+1.
- R6: The combined line output is low exactly when the pending set is non-empty. The umbrella flag, and with it the interrupt output, is set one cycle after a high-to-low transition of that line.
- R7: Writing 1 to data bit 0 at address 2 clears the umbrella flag on the next edge. If nothing is pending at the time of that write, the flag stays clear.
- R8: If the pending set is non-empty when the clear write takes effect, the flag reads 0 for one cycle and is set again on the following edge.
- R9: The index output gives the bit number (6 = slot F, down to 0 = slot 9) of the highest pending bit, and the valid output is high exactly when the pending set is non-empty.
- R10: A request on a slot whose mask bit is 0 does not change the pending set, the combined line or the interrupt output.
- R11: Reading address 2 returns the umbrella flag in bit 0. A write to address 2 with data bit 0 = 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_req_n | input | 7 | Active-low slot request lines, bit 6 = slot F |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| slot_irq | output | 1 | Umbrella interrupt flag |
| slot_line_n | output | 1 | Combined active-low line of enabled requests |
| top_idx | output | 3 | Bit number of the highest pending slot |
| top_valid | output | 1 | High when any slot is pending |

## Verification
The bench uses the default parameters: seven slots, an 8-bit data path and a two-stage synchroniser. With these values every mask pattern and the full descending priority order can be reached in a short run, and the two-cycle input latency can be observed directly. A behavioural model built on a delay line is compared with the outputs on every cycle. Directed sequences then cover the set and clear mask writes, masked requests, the re-arm after a clear while a request is still held, and a clear once all requests have gone away.

// File: rtl/slotagg_pkg.sv
package slotagg_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_MASK = 2'd0,
        RA_PEND = 2'd1,
        RA_FLAG = 2'd2,
        RA_RSVD = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/slotagg_sync.sv
module slotagg_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Idle level of an active-low request is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/slotagg_prio.sv
module slotagg_prio #(
    parameter int W  = 7,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);
    // Ascending scan: the last hit is the highest bit.
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i]) begin
                idx_o   = IW'(i);
                valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_irq_agg.sv
module slot_irq_agg
    import slotagg_pkg::*;
#(
    parameter int NUM_SLOTS   = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOTS-1:0]         slot_req_n,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [REG_AW-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         slot_irq,
    output logic                         slot_line_n,
    output logic [$clog2(NUM_SLOTS)-1:0] top_idx,
    output logic                         top_valid
);
    localparam int IDX_W   = $clog2(NUM_SLOTS);
    localparam int CTL_BIT = DATA_W - 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] mask;
        logic                 line_prev;
        logic                 flag;
        logic                 rearm;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] req_sync_n;
    logic [NUM_SLOTS-1:0] pend;
    logic                 pend_any;
    logic                 line_now;
    logic                 fall;
    logic                 mask_wr;
    logic                 flag_clr;
    logic [NUM_SLOTS-1:0] wr_bits;

    slotagg_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (slot_req_n),
        .dout  (req_sync_n)
    );

    slotagg_prio #(.W(NUM_SLOTS), .IW(IDX_W)) u_prio (
        .req_i   (pend),
        .idx_o   (top_idx),
        .valid_o (top_valid)
    );

    always_comb begin
        pend     = ~req_sync_n & st_q.mask;
        pend_any = |pend;
        line_now = ~pend_any;
        fall     = st_q.line_prev & ~line_now;
        wr_bits  = wr_data[NUM_SLOTS-1:0];
        mask_wr  = wr_en && (wr_addr == RA_MASK);
        flag_clr = wr_en && (wr_addr == RA_FLAG) && wr_data[0];

        st_d           = st_q;
        st_d.line_prev = line_now;
        if (mask_wr) begin
            if (wr_data[CTL_BIT]) st_d.mask = st_q.mask | wr_bits;
            else                  st_d.mask = st_q.mask & ~wr_bits;
        end
        // A new edge or a pending re-arm wins over a clear.
        st_d.flag  = fall | st_q.rearm | (st_q.flag & ~flag_clr);
        st_d.rearm = flag_clr & pend_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask      <= '0;
            st_q.line_prev <= 1'b1;
            st_q.flag      <= 1'b0;
            st_q.rearm     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_MASK: rd_data[NUM_SLOTS-1:0] = st_q.mask;
            RA_PEND: rd_data[NUM_SLOTS-1:0] = pend;
            RA_FLAG: rd_data[0]             = st_q.flag;
            default: rd_data                = '0;
        endcase
    end

    assign slot_irq    = st_q.flag;
    assign slot_line_n = line_now;

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && wr_data[CTL_BIT]) |=>
        ((st_q.mask & $past(wr_bits)) == $past(wr_bits)));

    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !wr_data[CTL_BIT]) |=> ((st_q.mask & $past(wr_bits)) == '0));

    assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> slot_irq);

    assert_clear_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fall && !st_q.rearm) |=> !slot_irq);

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && pend_any) |=> ##1 slot_irq);

    assert_top_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> pend[top_idx]);
endmodule

// File: tb/sim_slot_irq_agg.sv
module sim_slot_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] slot_req_n = 7'h7F;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       slot_irq;
    logic       slot_line_n;
    logic [2:0] top_idx;
    logic       top_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    slot_irq_agg u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_req_n  (slot_req_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .slot_irq    (slot_irq),
        .slot_line_n (slot_line_n),
        .top_idx     (top_idx),
        .top_valid   (top_valid)
    );

    // Behavioural reference: input delay line plus flag bookkeeping.
    logic [6:0] dly[$];
    logic [6:0] m_mask;
    bit         m_flag, m_idle_prev, m_rearm;

    function automatic logic [6:0] m_pend();
        return ~dly[0] & m_mask;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            dly = '{7'h7F, 7'h7F};
            m_mask = '0; m_flag = 0; m_idle_prev = 1; m_rearm = 0;
        end else begin
            logic [6:0] p;
            bit clr, fell, nf;
            p    = m_pend();
            clr  = wr_en && wr_addr == 2'd2 && wr_data[0];
            fell = m_idle_prev && (p != 0);
            nf   = fell || m_rearm || (m_flag && !clr);
            m_rearm     = clr && (p != 0);
            m_flag      = nf;
            m_idle_prev = (p == 0);
            if (wr_en && wr_addr == 2'd0)
                m_mask = wr_data[7] ? (m_mask | wr_data[6:0]) : (m_mask & ~wr_data[6:0]);
            void'(dly.pop_front());
            dly.push_back(slot_req_n);
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model.
    always @(negedge clk) begin
        if (rst_n && dly.size() == 2) begin
            logic [6:0] p;
            int hi;
            p  = m_pend();
            hi = 0;
            for (int i = 0; i < 7; i++) if (p[i]) hi = i;
            check("R6 irq", slot_irq, m_flag);
            check("R6 line", slot_line_n, (p == 0));
            check("R9 valid", top_valid, (p != 0));
            if (p != 0) check("R9 index", top_idx, hi);
            case (rd_addr)
                2'd0: check("R2 mask read", rd_data, {1'b0, m_mask});
                2'd1: check("R4 pending read", rd_data, {1'b0, p});
                2'd2: check("R11 flag read", rd_data, {7'b0, m_flag});
                default: check("R4 reserved read", rd_data, 0);
            endcase
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input int exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, "R1 mask after reset", 0);
        rd(2'd1, "R1 pending after reset", 0);
        check("R1 irq after reset", slot_irq, 0);
        check("R1 line after reset", slot_line_n, 1);

        // R2 / R3 mask writes
        wr(2'd0, 8'h85); rd(2'd0, "R2 set bits 2,0", 8'h05);
        wr(2'd0, 8'h81); rd(2'd0, "R2 set already-set bit", 8'h05);
        wr(2'd0, 8'hC0); rd(2'd0, "R2 set bit 6", 8'h45);
        wr(2'd0, 8'h04); rd(2'd0, "R3 clear bit 2", 8'h41);

        // R10 masked slot has no effect
        rd_addr = 2'd1;
        slot_req_n = 7'h77;
        repeat (4) @(negedge clk);
        rd(2'd1, "R10 masked pending", 0);
        check("R10 masked irq", slot_irq, 0);
        check("R10 masked line", slot_line_n, 1);

        // R5 synchroniser latency, R6 edge
        slot_req_n = 7'h76;
        @(negedge clk); rd(2'd1, "R5 not yet visible", 0);
        @(negedge clk); rd(2'd1, "R5 visible after two edges", 8'h01);
        check("R6 irq not yet", slot_irq, 0);
        check("R6 line low", slot_line_n, 0);
        @(negedge clk); check("R6 irq set", slot_irq, 1);

        // R9 priority
        slot_req_n = 7'h36;
        repeat (2) @(negedge clk);
        check("R9 top slot F", top_idx, 6);
        check("R9 valid", top_valid, 1);

        // R11 write without bit 0
        wr(2'd2, 8'h00);
        check("R11 no-op write", slot_irq, 1);

        // R8 re-arm while pending
        wr(2'd2, 8'h01);
        check("R8 flag dropped", slot_irq, 0);
        @(negedge clk);
        check("R8 flag re-set", slot_irq, 1);

        // R7 clear with nothing pending
        slot_req_n = 7'h7F;
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h01);
        repeat (3) @(negedge clk);
        check("R7 flag stays clear", slot_irq, 0);

        // R3 full clear
        wr(2'd0, 8'h7F); rd(2'd0, "R3 clear all", 0);
        slot_req_n = 7'h00;
        repeat (4) @(negedge clk);
        check("R10 all masked irq", slot_irq, 0);
        slot_req_n = 7'h7F;

        // Sweep patterns against the model
        wr(2'd0, 8'hFF);
        for (int k = 0; k < 40; k++) begin
            slot_req_n = 7'((k * 37 + 11) ^ (k << 2));
            rd_addr = 2'(k);
            if (k % 7 == 3) wr(2'd2, 8'h01);
            else @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule